// File: doc/BRIEF.md
# Command FIFO with Status Word

This block decouples a host that issues register-write commands from a drawing engine that consumes them. Each host write (an address and a 32-bit data value) is stored in a circular buffer and handed to the engine over a valid/ready output. Commands leave in the order they arrived, at most one per cycle.

A status word, readable at any time, gives software the information it needs for flow control and synchronisation. Bits 11:0 hold the number of free buffer entries. Bits 24 and 25 are two busy indications. Bits 30 and 31 are sticky error flags that software clears by writing ones. Software is expected to keep a safety margin of eight entries below the reported free count, so the default depth is well above eight.

Top module: `cmdq_stat`

## Requirements
- R1: Reset empties the buffer and clears both error flags. While in reset and directly after it, status bits 11:0 equal DEPTH and `cmd_valid` is 0.
- R2: Commands appear on `cmd_addr`/`cmd_data` in arrival order. With `cmd_ready` held high, one command leaves per cycle.
- R3: A host write that finds the buffer full, with no command leaving in that cycle, is discarded and sets status bit 31, the overflow flag.
- R4: Status bits 11:0 always equal DEPTH minus the number of stored commands.
- R5: Status bit 24 follows the `eng_fb_busy` input.
- R6: Status bit 25 is 1 whenever the buffer holds a command or `eng_rp_busy` is 1, and 0 otherwise.
- R7: A one-cycle pulse on `rd_err_evt` sets status bit 30, the read-error flag. The flag stays set until it is cleared.
- R8: A status write with bit 30 or bit 31 set to 1 clears that flag. Zeros in those positions, and all other bit positions, have no effect on the status word.
- R9: When a flag is set and cleared in the same cycle, setting wins and the flag reads 1 afterwards.
- R10: A host write to a full buffer in a cycle where a command also leaves is accepted: the free count stays 0, no overflow is flagged, and the new command is delivered last.
- R11: While `cmd_valid` is 1 and `cmd_ready` is 0, the presented command and `cmd_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host command write strobe |
| host_wr_addr | input | AW | Command register address |
| host_wr_data | input | 32 | Command data |
| stat_wr_en | input | 1 | Status write strobe (write-one-to-clear on bits 30, 31) |
| stat_wr_data | input | 32 | Status write value |
| stat_rd_data | output | 32 | Live status word |
| rd_err_evt | input | 1 | Read-error event pulse |
| eng_fb_busy | input | 1 | Engine frame-buffer side busy |
| eng_rp_busy | input | 1 | Engine raster side busy |
| cmd_valid | output | 1 | A command is presented to the engine |
| cmd_ready | input | 1 | Engine accepts the presented command |
| cmd_addr | output | AW | Presented command address |
| cmd_data | output | 32 | Presented command data |

## Verification
Two pairs of events can coincide. The first pair is a host write into a full buffer and a command leaving in the same cycle. The bench fills the buffer, then raises `cmd_ready` and `host_wr_en` together; it expects no overflow flag and expects the late command to come out last. The second pair is a flag being set and cleared in one cycle. The bench drives an overflowing write, a read-error pulse and a status write of ones to bits 30 and 31 on the same edge, and expects both flags to read 1 afterwards.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int FREE_W    = 12;
    localparam int POS_FB    = 24;
    localparam int POS_RP    = 25;
    localparam int POS_RDERR = 30;
    localparam int POS_OVF   = 31;
    localparam int NUM_FLAGS = 2;
    localparam int IDX_RD    = 0;
    localparam int IDX_OVF   = 1;
endpackage

// File: rtl/cmdq_ring.sv
module cmdq_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 40,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cmdq_sticky.sv
module cmdq_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d, flags_q;

    // Setting has priority over clearing in the same cycle.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            flags_d[i] = set_i[i] | (flags_q[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/cmdq_stat.sv
module cmdq_stat #(
    parameter int DEPTH = 16,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_en,
    input  logic [AW-1:0] host_wr_addr,
    input  logic [31:0]   host_wr_data,
    input  logic          stat_wr_en,
    input  logic [31:0]   stat_wr_data,
    output logic [31:0]   stat_rd_data,
    input  logic          rd_err_evt,
    input  logic          eng_fb_busy,
    input  logic          eng_rp_busy,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [AW-1:0] cmd_addr,
    output logic [31:0]   cmd_data
);
    import cmdq_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = AW + 32;
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t st_d, st_q;

    logic                 pop, push, drop, full;
    logic [EW-1:0]        head;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
    logic                 wr_unused;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full  = (st_q.cnt == CW'(DEPTH));
        pop   = (st_q.cnt != '0) && cmd_ready;
        push  = host_wr_en && (!full || pop);
        drop  = host_wr_en && !push;

        st_d = st_q;
        if (push) begin
            st_d.wr = step_ptr(st_q.wr);
        end
        if (pop) begin
            st_d.rd = step_ptr(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cmdq_ring #(.DEPTH(DEPTH), .W(EW)) u_ring (
        .clk   (clk),
        .we    (push),
        .waddr (st_q.wr),
        .wdata ({host_wr_addr, host_wr_data}),
        .raddr (st_q.rd),
        .rdata (head)
    );

    always_comb begin
        flag_set          = '0;
        flag_clr          = '0;
        flag_set[IDX_RD]  = rd_err_evt;
        flag_set[IDX_OVF] = drop;
        flag_clr[IDX_RD]  = stat_wr_en && stat_wr_data[POS_RDERR];
        flag_clr[IDX_OVF] = stat_wr_en && stat_wr_data[POS_OVF];
    end

    cmdq_sticky #(.N(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flag_q)
    );

    assign wr_unused = ^stat_wr_data[29:0];

    assign cmd_valid = (st_q.cnt != '0);
    assign cmd_addr  = head[EW-1:32];
    assign cmd_data  = head[31:0];

    always_comb begin
        stat_rd_data                = '0;
        stat_rd_data[FREE_W-1:0]    = FREE_W'(DEPTH) - FREE_W'(st_q.cnt);
        stat_rd_data[POS_FB]        = eng_fb_busy;
        stat_rd_data[POS_RP]        = cmd_valid || eng_rp_busy;
        stat_rd_data[POS_RDERR]     = flag_q[IDX_RD];
        stat_rd_data[POS_OVF]       = flag_q[IDX_OVF];
    end
endmodule

// File: rtl/cmdq_stat_chk.sv
module cmdq_stat_chk #(
    parameter int DEPTH = 16,
    parameter int AW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr_en,
    input logic          stat_wr_en,
    input logic [31:0]   stat_wr_data,
    input logic [31:0]   stat_rd_data,
    input logic          rd_err_evt,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [AW-1:0] cmd_addr,
    input logic [31:0]   cmd_data
);
    logic overflow_now;
    assign overflow_now = host_wr_en && (stat_rd_data[11:0] == 12'd0)
                          && !(cmd_valid && cmd_ready);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_now |=> stat_rd_data[31]);

    assert_free_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_data[11:0] <= 12'(DEPTH));

    assert_rp_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> stat_rd_data[25]);

    assert_rderr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_data[30] && !(stat_wr_en && stat_wr_data[30])) |=> stat_rd_data[30]);

    assert_rderr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_evt |=> stat_rd_data[30]);

    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_en && stat_wr_data[31] && !overflow_now) |=> !stat_rd_data[31]);

    assert_hold_head_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));
endmodule

bind cmdq_stat cmdq_stat_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .stat_wr_en   (stat_wr_en),
    .stat_wr_data (stat_wr_data),
    .stat_rd_data (stat_rd_data),
    .rd_err_evt   (rd_err_evt),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_addr     (cmd_addr),
    .cmd_data     (cmd_data)
);

// File: tb/cmdq_stat_test.sv
module cmdq_stat_test;
    localparam int DEPTH = 16;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_en = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic [31:0]   host_wr_data = '0;
    logic          stat_wr_en = 1'b0;
    logic [31:0]   stat_wr_data = '0;
    logic [31:0]   stat_rd_data;
    logic          rd_err_evt = 1'b0;
    logic          eng_fb_busy = 1'b0;
    logic          eng_rp_busy = 1'b0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [AW-1:0] cmd_addr;
    logic [31:0]   cmd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cmdq_stat #(.DEPTH(DEPTH), .AW(AW)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] mkd(input logic [AW-1:0] a);
        return 32'h5A00_0000 | (32'(a) << 8) | 32'(~a);
    endfunction

    task automatic push(input logic [AW-1:0] a);
        host_wr_en   = 1'b1;
        host_wr_addr = a;
        host_wr_data = mkd(a);
        step();
        host_wr_en   = 1'b0;
    endtask

    task automatic fill(input logic [AW-1:0] base, input int n);
        for (int i = 0; i < n; i++) push(base + AW'(i));
    endtask

    task automatic drain(input string tag, input logic [AW-1:0] base, input int n);
        cmd_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            chk({tag, " valid"}, 32'(cmd_valid), 32'd1);
            chk({tag, " addr"}, 32'(cmd_addr), 32'(base + AW'(i)));
            chk({tag, " data"}, cmd_data, mkd(base + AW'(i)));
            step();
        end
        cmd_ready = 1'b0;
    endtask

    task automatic swrite(input logic [31:0] v);
        stat_wr_en   = 1'b1;
        stat_wr_data = v;
        step();
        stat_wr_en   = 1'b0;
        stat_wr_data = '0;
    endtask

    task automatic t_reset();
        chk("R1 free in reset", 32'(stat_rd_data[11:0]), DEPTH);
        chk("R1 status in reset", stat_rd_data & 32'hC300_0000, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R1 free after reset", 32'(stat_rd_data[11:0]), DEPTH);
        chk("R1 valid after reset", 32'(cmd_valid), 32'd0);
        chk("R1 flags after reset", 32'(stat_rd_data[31:30]), 32'd0);
    endtask

    task automatic t_order();
        fill(8'h10, 5);
        chk("R4 free after 5", 32'(stat_rd_data[11:0]), DEPTH - 5);
        chk("R6 rp busy from queue", 32'(stat_rd_data[25]), 32'd1);
        step();
        step();
        chk("R11 head held addr", 32'(cmd_addr), 32'h10);
        chk("R11 head held data", cmd_data, mkd(8'h10));
        drain("R2 order", 8'h10, 5);
        chk("R2 empty after drain", 32'(cmd_valid), 32'd0);
        chk("R4 free after drain", 32'(stat_rd_data[11:0]), DEPTH);
    endtask

    task automatic t_overflow();
        fill(8'h40, DEPTH);
        chk("R4 free when full", 32'(stat_rd_data[11:0]), 32'd0);
        chk("R3 no ovf yet", 32'(stat_rd_data[31]), 32'd0);
        push(8'hFF);
        chk("R3 ovf set", 32'(stat_rd_data[31]), 32'd1);
        chk("R3 free still 0", 32'(stat_rd_data[11:0]), 32'd0);
        drain("R3 kept contents", 8'h40, DEPTH);
        chk("R3 dropped cmd absent", 32'(cmd_valid), 32'd0);
        swrite(32'h8000_0000);
        chk("R8 ovf cleared", 32'(stat_rd_data[31]), 32'd0);
    endtask

    task automatic t_full_pop();
        fill(8'h80, DEPTH);
        host_wr_en   = 1'b1;
        host_wr_addr = 8'hEE;
        host_wr_data = mkd(8'hEE);
        cmd_ready    = 1'b1;
        step();
        host_wr_en   = 1'b0;
        cmd_ready    = 1'b0;
        chk("R10 free stays 0", 32'(stat_rd_data[11:0]), 32'd0);
        chk("R10 no ovf", 32'(stat_rd_data[31]), 32'd0);
        drain("R10 rest", 8'h81, DEPTH - 1);
        drain("R10 late cmd last", 8'hEE, 1);
        chk("R10 empty", 32'(cmd_valid), 32'd0);
    endtask

    task automatic t_w1c();
        rd_err_evt = 1'b1;
        step();
        rd_err_evt = 1'b0;
        chk("R7 rderr set", 32'(stat_rd_data[30]), 32'd1);
        step();
        step();
        step();
        chk("R7 rderr sticky", 32'(stat_rd_data[30]), 32'd1);
        fill(8'h20, DEPTH);
        push(8'h99);
        chk("R3 ovf set again", 32'(stat_rd_data[31]), 32'd1);
        swrite(32'h3FFF_FFFF);
        chk("R8 other bits ignored", stat_rd_data & 32'hC000_0FFF, 32'hC000_0000);
        swrite(32'h4000_0000);
        chk("R8 clear rderr only", 32'(stat_rd_data[31:30]), 32'd2);
        swrite(32'h8000_0000);
        chk("R8 clear ovf", 32'(stat_rd_data[31:30]), 32'd0);
        drain("R8 contents intact", 8'h20, DEPTH);
        chk("R4 free restored", 32'(stat_rd_data[11:0]), DEPTH);
    endtask

    task automatic t_set_wins();
        fill(8'h60, DEPTH);
        host_wr_en   = 1'b1;
        host_wr_addr = 8'h77;
        host_wr_data = mkd(8'h77);
        rd_err_evt   = 1'b1;
        stat_wr_en   = 1'b1;
        stat_wr_data = 32'hC000_0000;
        step();
        host_wr_en   = 1'b0;
        rd_err_evt   = 1'b0;
        stat_wr_en   = 1'b0;
        stat_wr_data = '0;
        chk("R9 set beats clear", 32'(stat_rd_data[31:30]), 32'd3);
        swrite(32'hC000_0000);
        chk("R8 both cleared", 32'(stat_rd_data[31:30]), 32'd0);
        drain("R9 contents", 8'h60, DEPTH);
    endtask

    task automatic t_busy();
        eng_fb_busy = 1'b1;
        #1;
        chk("R5 fb busy", 32'(stat_rd_data[25:24]), 32'd1);
        eng_fb_busy = 1'b0;
        eng_rp_busy = 1'b1;
        #1;
        chk("R6 rp busy input", 32'(stat_rd_data[25:24]), 32'd2);
        eng_rp_busy = 1'b0;
        #1;
        chk("R6 idle", 32'(stat_rd_data[25:24]), 32'd0);
        step();
        push(8'h05);
        chk("R6 busy from queued cmd", 32'(stat_rd_data[25:24]), 32'd2);
        drain("R6 drain", 8'h05, 1);
        chk("R6 idle after drain", 32'(stat_rd_data[25]), 32'd0);
    endtask

    task automatic t_mid_reset();
        fill(8'h30, 3);
        rd_err_evt = 1'b1;
        step();
        rd_err_evt = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 reset empties", 32'(cmd_valid), 32'd0);
        chk("R1 reset free", 32'(stat_rd_data[11:0]), DEPTH);
        chk("R1 reset flags", 32'(stat_rd_data[31:30]), 32'd0);
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        #1;
        t_reset();
        t_order();
        t_overflow();
        t_full_pop();
        t_w1c();
        t_set_wins();
        t_busy();
        t_mid_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule